// File: doc/BRIEF.md
# Relative Branch Resolver

This block resolves a relative branch once the branch opcode and its signed 8-bit displacement are known. It judges whether the branch is taken from the N, Z, V and C condition flags and produces the program counter of the next instruction. It also raises a one-cycle strobe asking that a return address be pushed when the instruction is a branch to subroutine. The push itself and the fetch of the displacement byte are done elsewhere.

The upper nibble of the opcode marks the conditional branch group (0x2_). In that group, opcode bits [3:1] pick one of eight flag tests and bit [0] inverts it. The tests cover always, the unsigned higher test (C and Z), the single-flag tests, and the signed tests built from N XOR V. The fall-through address is the branch address plus two, which is the length of the branch instruction. The taken target adds the sign-extended displacement to that fall-through address. The decode is combinational and is followed by one register stage, so every result appears one clock after its request.

Top module: `brc_unit`

## Requirements
- R1: While reset is high, and at the first sample after it, `res_valid_o`, `taken_o` and `push_req_o` are 0 and `next_pc_o` is 0x0000.
- R2: A request with `req_valid_i`=1 produces `res_valid_o`=1 exactly one clock later. A cycle with `req_valid_i`=0 gives `res_valid_o`=0 one clock later.
- R3: Opcode 0x20 is always taken and opcode 0x21 is never taken, whatever the flags.
- R4: Opcode 0x22 is taken when (C OR Z)=0. Opcode 0x23 is taken when (C OR Z)=1.
- R5: Opcodes 0x24/0x25 are taken on C=0/C=1, 0x26/0x27 on Z=0/Z=1, 0x28/0x29 on V=0/V=1, and 0x2A/0x2B on N=0/N=1. The flags arrive on `flags_i` as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R6: Opcode 0x2C is taken when (N XOR V)=0 and 0x2D when (N XOR V)=1. Opcode 0x2E is taken when (Z OR (N XOR V))=0 and 0x2F when it is 1.
- R7: A taken result has `next_pc_o` = `pc_i` + 2 + the sign-extended `offset_i`, modulo 2^16. Offsets 0x7F and 0x80 reach +129 and -126 from the branch address.
- R8: A not-taken result has `next_pc_o` = `pc_i` + 2 modulo 2^16.
- R9: Opcode 0x8D is always taken and gives `push_req_o`=1 for its single result cycle. Every other opcode gives `push_req_o`=0.
- R10: Any opcode outside 0x20..0x2F and 0x8D gives `taken_o`=0, `push_req_o`=0 and `next_pc_o` = `pc_i` + 2.
- R11: A cycle with `res_valid_o`=0 shows `taken_o`=0 and `push_req_o`=0, whatever opcode and flags were presented without `req_valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request qualifier |
| opcode_i | input | 8 | Instruction opcode |
| offset_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Address of the branch opcode |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| res_valid_o | output | 1 | Result qualifier, one clock after the request |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| push_req_o | output | 1 | Return-address push strobe |

## Verification
All sixteen conditional opcodes are driven with all sixteen flag combinations. This covers every flag test and every inversion bit, and it separates the signed tests from the unsigned ones, for example N=1,V=1 against N=1,V=0. The displacements and addresses are varied so that a wrong sign extension or a wrong base shows up in the target. Extra patterns cover wrap-around at 0xFFFE and at 0x0001, the two extreme displacements, the subroutine branch, some opcodes outside the group, and idle cycles carrying branch opcodes, which would show any leak into the strobes.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int PC_W     = 16;
    localparam int OFS_W    = 8;
    localparam int OP_W     = 8;
    localparam int INSN_LEN = 2;

    localparam logic [3:0]      GROUP_NIB = 4'h2;
    localparam logic [OP_W-1:0] BSR_OP    = 8'h8D;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        TST_ALWAYS = 3'd0,
        TST_HI     = 3'd1,
        TST_CC     = 3'd2,
        TST_NE     = 3'd3,
        TST_VC     = 3'd4,
        TST_PL     = 3'd5,
        TST_GE     = 3'd6,
        TST_GT     = 3'd7
    } test_sel_e;

    typedef struct packed {
        logic taken;
        logic push;
    } decision_t;

    function automatic logic base_test(test_sel_e sel, flags_t f);
        logic sgn_lt;
        sgn_lt = f.n ^ f.v;
        case (sel)
            TST_ALWAYS: return 1'b1;
            TST_HI:     return ~(f.c | f.z);
            TST_CC:     return ~f.c;
            TST_NE:     return ~f.z;
            TST_VC:     return ~f.v;
            TST_PL:     return ~f.n;
            TST_GE:     return ~sgn_lt;
            default:    return ~(f.z | sgn_lt);
        endcase
    endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0] opcode_i,
    input  flags_t         flags_i,
    output decision_t      dec_o
);
    logic      in_group;
    logic      is_bsr;
    test_sel_e sel;

    always_comb begin
        in_group = (opcode_i[OPW-1:OPW-4] == GROUP_NIB);
        is_bsr   = (opcode_i == OPW'(BSR_OP));
        sel      = test_sel_e'(opcode_i[3:1]);
        dec_o.push  = is_bsr;
        dec_o.taken = is_bsr |
                      (in_group & (base_test(sel, flags_i) ^ opcode_i[0]));
    end
endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
    parameter int AW       = 16,
    parameter int OW       = 8,
    parameter int STEP     = 2,
    parameter bit PARALLEL = 1'b1
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] offset_i,
    input  logic          taken_i,
    output logic [AW-1:0] next_pc_o
);
    localparam int EXT_W = AW - OW;

    logic [AW-1:0] fall_pc;
    logic [AW-1:0] disp;

    always_comb begin
        fall_pc = pc_i + AW'(STEP);
        disp    = {{EXT_W{offset_i[OW-1]}}, offset_i};
    end

    generate
        if (PARALLEL) begin : g_two_sums
            logic [AW-1:0] jump_pc;
            always_comb begin
                jump_pc   = fall_pc + disp;
                next_pc_o = taken_i ? jump_pc : fall_pc;
            end
        end else begin : g_one_sum
            always_comb begin
                next_pc_o = fall_pc + (taken_i ? disp : '0);
            end
        end
    endgenerate
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int  ADDR_W   = PC_W,
    parameter int  DISP_W   = OFS_W,
    parameter int  STEP     = INSN_LEN,
    parameter bit  PARALLEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [DISP_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [3:0]        flags_i,
    output logic              res_valid_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              push_req_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    decision_t         dec_c;
    logic [ADDR_W-1:0] next_c;

    brc_cond_eval #(.OPW(OP_W)) u_cond (
        .opcode_i (opcode_i),
        .flags_i  (flags_t'(flags_i)),
        .dec_o    (dec_c)
    );

    brc_target_calc #(
        .AW       (ADDR_W),
        .OW       (DISP_W),
        .STEP     (STEP),
        .PARALLEL (PARALLEL)
    ) u_tgt (
        .pc_i      (pc_i),
        .offset_i  (offset_i),
        .taken_i   (dec_c.taken),
        .next_pc_o (next_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            push_req_o  <= 1'b0;
            next_pc_o   <= '0;
        end else begin
            res_valid_o <= req_valid_i;
            taken_o     <= req_valid_i & dec_c.taken;
            push_req_o  <= req_valid_i & dec_c.push;
            if (req_valid_i) next_pc_o <= next_c;
        end
    end

    // R2: result qualifier trails the request by one clock
    a_r2_valid_lat: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> res_valid_o);

    // R3: unconditional opcode always yields a taken result
    a_r3_always: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && opcode_i == 8'h20) |=> taken_o);

    // R8: fall-through address is the request address plus the step
    a_r8_fallthru: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !taken_o) |-> next_pc_o == ADDR_W'($past(pc_i) + ADDR_W'(STEP)));

    // R7: taken address adds the sign-extended displacement
    a_r7_target: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && taken_o) |-> next_pc_o == ADDR_W'($past(pc_i) + ADDR_W'(STEP)
            + {{EXT_W{$past(offset_i[DISP_W-1])}}, $past(offset_i)}));

    // R9: push strobe only ever comes with a taken result
    a_r9_push_taken: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> taken_o);

    // R10: opcodes outside the branch set never resolve as taken
    a_r10_other: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && opcode_i[7:4] != 4'h2 && opcode_i != 8'h8D) |=> !taken_o);

    // R11: idle result cycles keep both strobes low
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !res_valid_o |-> (!taken_o && !push_req_o));
endmodule

// File: tb/brc_unit_bench.sv
module brc_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [7:0]  offset_i = 8'h00;
    logic [15:0] pc_i = 16'h0000;
    logic [3:0]  flags_i = 4'h0;
    logic        res_valid_o;
    logic        taken_o;
    logic [15:0] next_pc_o;
    logic        push_req_o;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    typedef struct packed {
        logic        vld;
        logic        tk;
        logic        ps;
        logic [15:0] pc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    brc_unit u_brc_unit (
        .clk         (clk),
        .rst         (rst),
        .req_valid_i (req_valid_i),
        .opcode_i    (opcode_i),
        .offset_i    (offset_i),
        .pc_i        (pc_i),
        .flags_i     (flags_i),
        .res_valid_o (res_valid_o),
        .taken_o     (taken_o),
        .next_pc_o   (next_pc_o),
        .push_req_o  (push_req_o)
    );

    function automatic logic model_taken(logic [7:0] op, logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        case (op)
            8'h20: return 1'b1;
            8'h21: return 1'b0;
            8'h22: return (c | z) == 1'b0;
            8'h23: return (c | z) == 1'b1;
            8'h24: return c == 1'b0;
            8'h25: return c == 1'b1;
            8'h26: return z == 1'b0;
            8'h27: return z == 1'b1;
            8'h28: return v == 1'b0;
            8'h29: return v == 1'b1;
            8'h2A: return n == 1'b0;
            8'h2B: return n == 1'b1;
            8'h2C: return (n ^ v) == 1'b0;
            8'h2D: return (n ^ v) == 1'b1;
            8'h2E: return (z | (n ^ v)) == 1'b0;
            8'h2F: return (z | (n ^ v)) == 1'b1;
            8'h8D: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic vld, input logic [7:0] op, input logic [7:0] off,
                         input logic [15:0] pc, input logic [3:0] f, input string tag);
        exp_t e;
        logic [15:0] sx;
        @(negedge clk);
        req_valid_i = vld;
        opcode_i    = op;
        offset_i    = off;
        pc_i        = pc;
        flags_i     = f;
        sx     = {{8{off[7]}}, off};
        e.vld  = vld;
        e.tk   = vld & model_taken(op, f);
        e.ps   = vld & (op == 8'h8D);
        e.pc   = e.tk ? 16'(pc + 16'd2 + sx) : 16'(pc + 16'd2);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_en = 1'b1;
    endtask

    always @(posedge clk) begin
        #5;
        if (mon_en && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (res_valid_o !== e.vld || taken_o !== e.tk || push_req_o !== e.ps ||
                (e.vld && next_pc_o !== e.pc)) begin
                errors++;
                $display("FAIL %s op=%02h: got v=%b t=%b p=%b pc=%04h exp v=%b t=%b p=%b pc=%04h",
                         t, opcode_i, res_valid_o, taken_o, push_req_o, next_pc_o,
                         e.vld, e.tk, e.ps, e.pc);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (res_valid_o !== 1'b0 || taken_o !== 1'b0 || push_req_o !== 1'b0 || next_pc_o !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b t=%b p=%b pc=%04h exp 0 0 0 0000",
                     res_valid_o, taken_o, push_req_o, next_pc_o);
        end
        rst = 1'b0;
        @(posedge clk); #5;
        checks++;
        if (res_valid_o !== 1'b0 || taken_o !== 1'b0 || push_req_o !== 1'b0 || next_pc_o !== 16'h0) begin
            errors++;
            $display("FAIL R1 after reset: got v=%b t=%b p=%b pc=%04h exp 0 0 0 0000",
                     res_valid_o, taken_o, push_req_o, next_pc_o);
        end

        // R3 R4 R5 R6 R7 R8: every conditional opcode with every flag set
        for (int op = 8'h20; op <= 8'h2F; op++) begin
            for (int f = 0; f < 16; f++) begin
                logic [7:0]  off;
                logic [15:0] pc;
                off = 8'((op * 37 + f * 11) ^ (f << 4));
                pc  = 16'(16'h1000 + op * 16'h0101 + f * 16'h0013);
                drive(1'b1, 8'(op), off, pc, 4'(f), "R3/R4/R5/R6 cond, R7/R8 target");
            end
        end

        // R7: wrap and reach limits
        drive(1'b1, 8'h20, 8'h05, 16'hFFFE, 4'h0, "R7 wrap up");
        drive(1'b1, 8'h20, 8'h80, 16'h0001, 4'h0, "R7 wrap down");
        drive(1'b1, 8'h20, 8'h7F, 16'h4000, 4'h0, "R7 max forward");
        drive(1'b1, 8'h20, 8'h80, 16'h4000, 4'h0, "R7 max backward");
        drive(1'b1, 8'h20, 8'hFE, 16'h2345, 4'h0, "R7 self loop");
        // R8: fall-through wrap
        drive(1'b1, 8'h21, 8'h40, 16'hFFFF, 4'h0, "R8 wrap");
        drive(1'b1, 8'h27, 8'h90, 16'hFFFE, 4'h0, "R8 wrap cond");
        // R9: subroutine branch, with flags that would fail other tests
        drive(1'b1, 8'h8D, 8'hF0, 16'h8000, 4'hF, "R9 bsr back");
        drive(1'b1, 8'h8D, 8'h10, 16'hFFF0, 4'h0, "R9 bsr fwd");
        drive(1'b1, 8'h20, 8'h10, 16'h8000, 4'h0, "R9 no push on bra");
        // R10: opcodes outside the set
        drive(1'b1, 8'h8C, 8'h10, 16'h1234, 4'h0, "R10 near bsr");
        drive(1'b1, 8'h1F, 8'h10, 16'h1234, 4'h0, "R10 below group");
        drive(1'b1, 8'h30, 8'h10, 16'h1234, 4'hF, "R10 above group");
        drive(1'b1, 8'hAD, 8'h10, 16'h1234, 4'h0, "R10 low nibble match");
        drive(1'b1, 8'h00, 8'h10, 16'hFFFE, 4'h0, "R10 wrap");
        // R11 R2: idle cycles carrying branch opcodes
        drive(1'b0, 8'h8D, 8'h10, 16'h5555, 4'h0, "R11 idle bsr");
        drive(1'b0, 8'h20, 8'h10, 16'h5555, 4'h0, "R11 idle bra");
        drive(1'b1, 8'h26, 8'h03, 16'h0100, 4'h0, "R2 after idle");
        drive(1'b0, 8'h2F, 8'h03, 16'h0100, 4'hF, "R2 idle follows");
        drive(1'b1, 8'h25, 8'h03, 16'h0200, 4'h1, "R2 back to back a");
        drive(1'b1, 8'h25, 8'h03, 16'h0300, 4'h0, "R2 back to back b");

        @(negedge clk);
        req_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 results missing: got %0d pending exp 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule